// File: doc/BRIEF.md
# Split seconds/nanoseconds precision time counter

This block keeps a precision time-of-day clock in two 32-bit fields: whole seconds, and nanoseconds inside the current second. Every clock cycle the nanosecond field grows by a programmable step. When the sum reaches one billion, one billion is taken off and the seconds field goes up by one in the same cycle. A legacy mode runs the nanosecond register as one 64-bit nanosecond count with no split into seconds.

Software reads and writes the time and the step through a small register port with a fixed address map. A capture strobe freezes a packed 64-bit timestamp for packet timestamping: seconds in the upper half, nanoseconds in the lower half. A combinational converter turns such a packed stamp back into a flat count of nanoseconds. The converter also takes the legacy format, which it passes through unchanged.

Software gets a consistent value by reading seconds, then nanoseconds, then seconds again. If the second seconds value is larger, it reads nanoseconds once more and pairs that value with the newer seconds.

Top module: `ptp_sec_ns_clock`

## Requirements
- R1: While the asynchronous active-low reset is held, the nanosecond and seconds fields and the captured stamp read zero, and the step reads 4.
- R2: With fmt_split high, each rising edge adds the step to the nanosecond field. A sum of 1,000,000,000 or more has 1,000,000,000 removed, and the seconds field gains one on that same edge. Outside a write, the nanosecond field never holds 1,000,000,000 or more.
- R3: The seconds field wraps from 0xFFFFFFFF to 0 on a carry.
- R4: With fmt_split low, the nanosecond register is a free 64-bit count that gains the step on every edge, with no wrap at one billion. The seconds field holds its value.
- R5: Reads are combinational in the same cycle. Address 0xF10 returns the nanosecond register, 0xF18 returns the step in bits 31:0, and 0xFD0 returns the seconds in bits 31:0. Unused bits and any other address read zero.
- R6: A write (reg_we high) takes effect on the next edge and overrides counting for the field written. A nanosecond write suppresses that edge's carry. A step write of 1,000,000,000 or more is ignored, and so is a nanosecond write of that size while fmt_split is high.
- R7: On the first edge at which fmt_split is high after an edge at which it was low, the nanosecond field is cleared to zero, unless that field is written on the same edge.
- R8: When cap_stb is high at an edge, cap_ts loads the values from before that edge. In split mode it loads {seconds, nanoseconds[31:0]}, and in legacy mode the 64-bit nanosecond register. Otherwise cap_ts holds.
- R9: With fmt_split high, conv_out = conv_in[63:32] × 1,000,000,000 + conv_in[31:0]. With fmt_split low, conv_out = conv_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_split | input | 1 | 1: split seconds/nanoseconds format, 0: legacy flat nanoseconds |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address for reads and writes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| cap_stb | input | 1 | Timestamp capture strobe |
| cap_ts | output | 64 | Last captured timestamp |
| conv_in | input | 64 | Timestamp to convert |
| conv_out | output | 64 | Flat nanosecond value of conv_in |

## Verification
Register reads and the converter are combinational, so the bench samples them a fraction of a nanosecond after it sets the address or the input, well before the next edge. Counting, writes, mode entry and capture each land exactly one edge after the inputs that cause them. The bench advances its reference model once per rising edge, using the inputs held across that edge, and compares the outputs one nanosecond later. Directed runs place the nanosecond field a few steps below one billion and the seconds field at its maximum, so that the exact edge of each carry and each wrap is checked.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;
  localparam longint unsigned NS_PER_SEC = 64'd1_000_000_000;
  localparam int unsigned     MAP_AW     = 12;
  localparam logic [MAP_AW-1:0] OFS_NSEC = 12'hF10;
  localparam logic [MAP_AW-1:0] OFS_STEP = 12'hF18;
  localparam logic [MAP_AW-1:0] OFS_SECS = 12'hFD0;
endpackage

// File: rtl/ptp_ns_advance.sv
module ptp_ns_advance
  import ptp_time_pkg::*;
#(
  parameter int unsigned NS_W = 64
) (
  input  logic              split,
  input  logic [NS_W-1:0]   ns_cur,
  input  logic [NS_W/2-1:0] step,
  output logic [NS_W-1:0]   ns_next,
  output logic              carry
);
  localparam int unsigned HALF = NS_W / 2;

  logic [HALF:0] sum;
  logic [HALF:0] sum_adj;
  logic          wrap;

  always_comb begin
    sum     = {1'b0, ns_cur[HALF-1:0]} + {1'b0, step};
    wrap    = (sum >= (HALF+1)'(NS_PER_SEC));
    sum_adj = wrap ? (sum - (HALF+1)'(NS_PER_SEC)) : sum;
    if (split) begin
      ns_next = NS_W'(sum_adj[HALF-1:0]);
      carry   = wrap;
    end else begin
      ns_next = ns_cur + NS_W'(step);
      carry   = 1'b0;
    end
  end
endmodule

// File: rtl/ptp_flat_conv.sv
module ptp_flat_conv
  import ptp_time_pkg::*;
#(
  parameter int unsigned NS_W = 64
) (
  input  logic            split,
  input  logic [NS_W-1:0] stamp,
  output logic [NS_W-1:0] flat
);
  localparam int unsigned HALF = NS_W / 2;

  logic [NS_W-1:0] whole_ns;

  always_comb begin
    whole_ns = NS_W'(stamp[NS_W-1:HALF]) * NS_W'(NS_PER_SEC);
    flat     = split ? (whole_ns + NS_W'(stamp[HALF-1:0])) : stamp;
  end
endmodule

// File: rtl/ptp_reg_read.sv
module ptp_reg_read
  import ptp_time_pkg::*;
#(
  parameter int unsigned NS_W = 64
) (
  input  logic [MAP_AW-1:0] addr,
  input  logic [NS_W-1:0]   ns_val,
  input  logic [NS_W/2-1:0] step_val,
  input  logic [NS_W/2-1:0] sec_val,
  output logic [NS_W-1:0]   rdata
);
  always_comb begin
    unique case (addr)
      OFS_NSEC: rdata = ns_val;
      OFS_STEP: rdata = NS_W'(step_val);
      OFS_SECS: rdata = NS_W'(sec_val);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptp_sec_ns_clock.sv
module ptp_sec_ns_clock
  import ptp_time_pkg::*;
#(
  parameter int unsigned NS_W      = 64,
  parameter int unsigned STEP_INIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fmt_split,
  input  logic              reg_we,
  input  logic [MAP_AW-1:0] reg_addr,
  input  logic [NS_W-1:0]   reg_wdata,
  output logic [NS_W-1:0]   reg_rdata,
  input  logic              cap_stb,
  output logic [NS_W-1:0]   cap_ts,
  input  logic [NS_W-1:0]   conv_in,
  output logic [NS_W-1:0]   conv_out
);
  localparam int unsigned HALF = NS_W / 2;

  logic [NS_W-1:0] ns_q, ns_d, adv_ns;
  logic [HALF-1:0] sec_q, sec_d;
  logic [HALF-1:0] inc_q, inc_d;
  logic [NS_W-1:0] cap_d;
  logic            mode_q;
  logic            adv_carry;
  logic            wr_ns, wr_sec, wr_inc, ns_wr_ok, inc_en, enter_split;

  ptp_ns_advance #(.NS_W(NS_W)) u_adv (
    .split   (fmt_split),
    .ns_cur  (ns_q),
    .step    (inc_q),
    .ns_next (adv_ns),
    .carry   (adv_carry)
  );

  ptp_reg_read #(.NS_W(NS_W)) u_rd (
    .addr     (reg_addr),
    .ns_val   (ns_q),
    .step_val (inc_q),
    .sec_val  (sec_q),
    .rdata    (reg_rdata)
  );

  ptp_flat_conv #(.NS_W(NS_W)) u_conv (
    .split (fmt_split),
    .stamp (conv_in),
    .flat  (conv_out)
  );

  // next-state logic
  always_comb begin
    wr_ns       = reg_we && (reg_addr == OFS_NSEC);
    wr_sec      = reg_we && (reg_addr == OFS_SECS);
    wr_inc      = reg_we && (reg_addr == OFS_STEP);
    ns_wr_ok    = !fmt_split || (reg_wdata < NS_W'(NS_PER_SEC));
    inc_en      = wr_inc && (reg_wdata < NS_W'(NS_PER_SEC));
    inc_d       = reg_wdata[HALF-1:0];
    enter_split = fmt_split && !mode_q;

    ns_d  = adv_ns;
    sec_d = sec_q + HALF'(adv_carry);
    if (wr_ns && ns_wr_ok) begin
      ns_d  = fmt_split ? NS_W'(reg_wdata[HALF-1:0]) : reg_wdata;
      sec_d = sec_q;
    end else if (enter_split) begin
      ns_d  = '0;
      sec_d = sec_q;
    end
    if (wr_sec) begin
      sec_d = reg_wdata[HALF-1:0];
    end

    cap_d = fmt_split ? {sec_q, ns_q[HALF-1:0]} : ns_q;
  end

  // time fields, advance every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      sec_q  <= '0;
      mode_q <= 1'b1;
    end else begin
      ns_q   <= ns_d;
      sec_q  <= sec_d;
      mode_q <= fmt_split;
    end
  end

  // step register, enabled by a valid write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q <= HALF'(STEP_INIT);
    end else if (inc_en) begin
      inc_q <= inc_d;
    end
  end

  // capture register, enabled by the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_ts <= '0;
    end else if (cap_stb) begin
      cap_ts <= cap_d;
    end
  end
endmodule

// File: rtl/ptp_sec_ns_clock_chk.sv
module ptp_sec_ns_clock_chk
  import ptp_time_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fmt_split,
  input logic              reg_we,
  input logic              cap_stb,
  input logic [MAP_AW-1:0] reg_addr,
  input logic [63:0]       cap_ts,
  input logic [63:0]       ns_q,
  input logic [31:0]       sec_q,
  input logic [31:0]       inc_q,
  input logic              mode_q,
  input logic [63:0]       conv_in,
  input logic [63:0]       conv_out
);
  // R2
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fmt_split) |-> (ns_q < 64'(NS_PER_SEC)));

  // R2 R3
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt_split) && $past(mode_q) && !$past(reg_we) && (ns_q < $past(ns_q)))
      |-> (sec_q == 32'($past(sec_q) + 32'd1)));

  // R2
  sec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fmt_split) && !$past(reg_we) && (ns_q >= $past(ns_q))) |-> $stable(sec_q));

  // R4
  legacy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fmt_split) && !$past(reg_we))
      |-> ((ns_q == $past(ns_q) + 64'($past(inc_q))) && $stable(sec_q)));

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && (reg_addr == OFS_STEP)) |=> $stable(inc_q));

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_stb |=> $stable(cap_ts));

  // R9
  always_comb begin
    if (rst_n && fmt_split) begin
      conv_floor_chk: assert (conv_out >= 64'(conv_in[31:0]));
    end
  end
endmodule

bind ptp_sec_ns_clock ptp_sec_ns_clock_chk u_chk (.*);

// File: tb/ptp_sec_ns_clock_test.sv
`timescale 1ns/100ps
module ptp_sec_ns_clock_test;
  import ptp_time_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, fmt_split, reg_we, cap_stb;
  logic [11:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata, cap_ts, conv_in, conv_out;

  always #2 clk = ~clk;

  ptp_sec_ns_clock uut (
    .clk(clk), .rst_n(rst_n), .fmt_split(fmt_split), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_stb(cap_stb), .cap_ts(cap_ts), .conv_in(conv_in), .conv_out(conv_out)
  );

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [63:0] m_ns, m_cap;
  logic [31:0] m_sec, m_inc;
  logic        m_mq;
  localparam logic [63:0] BIL = 64'd1_000_000_000;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] flat(input logic split, input logic [63:0] ts);
    return split ? (64'(ts[63:32]) * BIL + 64'(ts[31:0])) : ts;
  endfunction

  task automatic model_edge();
    logic [63:0] adv, s, nns;
    logic        c;
    logic [31:0] nsec, ninc;
    c = 1'b0;
    if (fmt_split) begin
      s = 64'(m_ns[31:0]) + 64'(m_inc);
      if (s >= BIL) begin s = s - BIL; c = 1'b1; end
      adv = s;
    end else adv = m_ns + 64'(m_inc);
    nns  = adv;
    nsec = m_sec + 32'(c);
    ninc = m_inc;
    if (reg_we && reg_addr == 12'hF10 && (!fmt_split || reg_wdata < BIL)) begin
      nns  = fmt_split ? 64'(reg_wdata[31:0]) : reg_wdata;
      nsec = m_sec;
    end else if (fmt_split && !m_mq) begin
      nns  = 64'd0;
      nsec = m_sec;
    end
    if (reg_we && reg_addr == 12'hFD0) nsec = reg_wdata[31:0];
    if (reg_we && reg_addr == 12'hF18 && reg_wdata < BIL) ninc = reg_wdata[31:0];
    if (cap_stb) m_cap = fmt_split ? {m_sec, m_ns[31:0]} : m_ns;
    m_ns  = nns;
    m_sec = nsec;
    m_inc = ninc;
    m_mq  = fmt_split;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    reg_we  = 1'b0;
    cap_stb = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
  endtask

  task automatic check_all(input string req);
    logic [63:0] d;
    rd(12'hF10, d); chk({req, " R5 ns"}, d, m_ns);
    rd(12'hFD0, d); chk({req, " R5 sec"}, d, 64'(m_sec));
    rd(12'hF18, d); chk({req, " R5 step"}, d, 64'(m_inc));
    chk("R8 cap", cap_ts, m_cap);
    conv_in = cap_ts;
    #0.2;
    chk("R9 conv", conv_out, flat(fmt_split, cap_ts));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, prev;
    void'($urandom(32'd13));
    rst_n = 1'b0; fmt_split = 1'b1; reg_we = 1'b0; cap_stb = 1'b0;
    reg_addr = 12'h0; reg_wdata = 64'd0; conv_in = 64'd0;
    m_ns = 0; m_sec = 0; m_inc = 32'd4; m_mq = 1'b1; m_cap = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    rd(12'hF10, d); chk("R1 ns", d, 64'd0);
    rd(12'hFD0, d); chk("R1 sec", d, 64'd0);
    rd(12'hF18, d); chk("R1 step", d, 64'd4);
    chk("R1 cap", cap_ts, 64'd0);
    rst_n = 1'b1;

    // constrained random in split mode
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom_range(0, 15);
      if (r == 0)
        wr(12'hF18, ($urandom_range(0, 7) == 0) ? BIL + 64'($urandom_range(0, 99))
                                                : 64'($urandom_range(0, 999_999_999)));
      else if (r == 1)
        wr(12'hF10, ($urandom_range(0, 7) == 0) ? BIL + 64'($urandom_range(0, 99))
                                                : 64'($urandom_range(0, 999_999_999)));
      else if (r == 2)
        wr(12'hFD0, ($urandom_range(0, 1) == 0) ? 64'(32'hFFFF_FFF0 + 32'($urandom_range(0, 15)))
                                                : 64'($urandom()));
      cap_stb = 1'($urandom_range(0, 1));
      step();
      check_all("R2 R6");
    end

    // R2 directed carry at exactly one billion
    wr(12'hF18, 64'd4); step();
    wr(12'hFD0, 64'd7); step();
    wr(12'hF10, 64'd999_999_996); step();
    check_all("R6");
    rd(12'hF10, d); chk("R6 ns write", d, 64'd999_999_996);
    rd(12'hFD0, d); chk("R6 no carry on write", d, 64'd7);
    step();
    rd(12'hF10, d); chk("R2 ns wrap", d, 64'd0);
    rd(12'hFD0, d); chk("R2 sec carry", d, 64'd8);

    // R6 oversize writes ignored
    wr(12'hF10, BIL); step();
    rd(12'hF10, d); chk("R6 ns oversize ignored", d, 64'd4);
    wr(12'hF18, BIL); step();
    rd(12'hF18, d); chk("R6 step oversize ignored", d, 64'd4);

    // R3 seconds wrap
    wr(12'hFD0, 64'hFFFF_FFFF); step();
    wr(12'hF10, 64'd999_999_998); step();
    step();
    rd(12'hF10, d); chk("R3 ns", d, 64'd2);
    rd(12'hFD0, d); chk("R3 sec wrap", d, 64'd0);
    check_all("R3");

    // R9 monotonic converter over captured stamps
    wr(12'hF18, 64'd123_456_789); step();
    cap_stb = 1'b1; step();
    conv_in = cap_ts; #0.2; prev = conv_out;
    for (int i = 0; i < 40; i++) begin
      cap_stb = 1'b1;
      step();
      rd(12'hF10, d);
      checks++;
      if (d >= BIL) begin errors++; $display("FAIL R2 ns range actual=%0d expected<%0d", d, BIL); end
      conv_in = cap_ts; #0.2;
      checks++;
      if (conv_out <= prev) begin
        errors++;
        $display("FAIL R9 monotonic actual=%0d expected>%0d", conv_out, prev);
      end
      prev = conv_out;
      chk("R8 R9 capture", cap_ts, m_cap);
    end

    // R4 legacy flat count across the 32-bit boundary
    wr(12'hF18, 64'd4); step();
    fmt_split = 1'b0;
    wr(12'hF10, 64'hFFFF_FFFE); step();
    rd(12'hFD0, prev);
    step();
    rd(12'hF10, d); chk("R4 legacy count", d, 64'h1_0000_0002);
    rd(12'hFD0, d); chk("R4 sec holds", d, prev);
    wr(12'hF10, 64'd5_000_000_000); step();
    rd(12'hF10, d); chk("R6 legacy large write", d, 64'd5_000_000_000);
    cap_stb = 1'b1; step();
    chk("R8 legacy capture", cap_ts, 64'd5_000_000_000);
    conv_in = cap_ts; #0.2;
    chk("R9 legacy passthrough", conv_out, 64'd5_000_000_000);
    check_all("R4");

    // R7 return to split clears nanoseconds
    fmt_split = 1'b1; step();
    rd(12'hF10, d); chk("R7 ns cleared", d, 64'd0);
    step();
    rd(12'hF10, d); chk("R7 counting resumes", d, 64'd4);

    // R5 unmapped address
    rd(12'h100, d); chk("R5 unmapped", d, 64'd0);

    // R9 directed conversion
    conv_in = {32'd3, 32'd17}; #0.2;
    chk("R9 split conv", conv_out, 64'd3_000_000_017);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule